// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block changes the settings of an analog PLL safely while the clock tree around it keeps running. A reprogram request carries a new feedback multiplier, input predivider, output shift and fractional word. If the output clock select is on the PLL path, the sequencer first moves it to the slow reference. It then powers the PLL down, loads the new values and powers it up again. It waits for the lock flag, counting reference cycles as it waits. When it is finished it puts the clock select back on the PLL path, but only if this sequence was the one that moved it.

When the PLL does not lock in time, the sequencer raises a one-cycle error pulse and runs the whole programming sequence a second time with the values that were in force before the request. It makes at most one such second attempt. If the restore also fails to lock, a failure flag accompanies the completion pulse. Two shorter commands are also accepted. One powers the PLL up and waits for lock. The other only powers it down. A direct write sets the clock select while the sequencer is idle.

Top module: `pll_reprog_seq`

## Requirements
- R1: After a synchronous active-high reset the sequencer is idle (busy 0, done 0), powerdown is 0, the clock select is slow (mux_normal 0) and all four setting outputs are 0.
- R2: A clock-select write while idle sets mux_normal to mux_wr_normal from the next cycle on. It causes no busy cycle.
- R3: After a request is accepted, mux_normal goes to 0 one cycle later (if it was 1), and powerdown rises one cycle after that. The setting outputs change only in a cycle where powerdown was already 1 and stays 1.
- R4: A request loads its four values onto cfg_m, cfg_p, cfg_s and cfg_k, then releases powerdown and waits for lock. Lock is seen in wait cycle d, where wait cycle 0 is the first cycle after powerdown falls. The done pulse then comes d+7 cycles after the accepting clock edge, with fail 0.
- R5: The wait gives up after LOCK_TIMEOUT wait cycles without lock (default 24000). A lock seen in the last of these cycles (d = LOCK_TIMEOUT-1) still counts as success.
- R6: When the first attempt of a request times out, err pulses for exactly one cycle. The sequence then reruns with the settings that were in force before the request. If that restore locks in wait cycle d, done comes LOCK_TIMEOUT+d+10 cycles after acceptance with fail 0.
- R7: A restore is attempted at most once. If it also times out, done comes 2*LOCK_TIMEOUT+9 cycles after acceptance, with fail 1, the restored settings on the outputs and err having pulsed only once.
- R8: At the end of a request, mux_normal returns to 1 if and only if it was 1 when the request was accepted. This holds for a failed restore as well.
- R9: An enable command while idle clears powerdown in the next cycle and waits for lock. done comes d+3 cycles after acceptance. A disable command while idle sets powerdown, and done comes 1 cycle after acceptance. Neither command changes the settings or the clock select.
- R10: The enabled output is always the inverse of powerdown.
- R11: busy is 1 from the cycle after acceptance through the done cycle. While busy, requests, enable, disable and clock-select writes are ignored. If several commands arrive together while idle, a request wins over enable, enable over disable, and disable over a clock-select write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Reprogram request strobe |
| req_m | input | M_W | Requested multiplier |
| req_p | input | P_W | Requested predivider |
| req_s | input | S_W | Requested output shift |
| req_k | input | K_W | Requested fractional word |
| en_cmd | input | 1 | Power-up-and-lock command |
| dis_cmd | input | 1 | Power-down command |
| mux_wr | input | 1 | Clock-select write strobe |
| mux_wr_normal | input | 1 | Clock-select value for a write (1 = PLL path) |
| lock_in | input | 1 | PLL lock status |
| mux_normal | output | 1 | Clock select: 1 = PLL path, 0 = slow reference |
| pll_pd | output | 1 | PLL powerdown control |
| cfg_m | output | M_W | Applied multiplier |
| cfg_p | output | P_W | Applied predivider |
| cfg_s | output | S_W | Applied output shift |
| cfg_k | output | K_W | Applied fractional word |
| enabled | output | 1 | PLL powered (inverse of pll_pd) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Final lock failure, valid with done |
| err | output | 1 | One-cycle pulse on first-attempt timeout |

## Verification
The lock flag and the expiry of the timeout can land in the same wait cycle. The bench provokes this with a lock model whose delay is exactly LOCK_TIMEOUT-1 wait cycles. In that cycle, lock must win: no err pulse, the new settings kept, and done after LOCK_TIMEOUT+6 cycles. One cycle more of delay must turn the outcome into a timeout with restore, judged by the err count, the fail flag, the restored settings and the exact done latency.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PARK,
      ST_PDOWN,
      ST_LOAD,
      ST_PUP,
      ST_WAIT,
      ST_UNPARK,
      ST_FIN
   } seq_state_e;

endpackage

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
   parameter int LIMIT = 24000
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   output logic expired
);
   localparam int CW = $clog2(LIMIT);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("pll_lock_timer: LIMIT must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         cnt <= '0;
      end else if (cnt != LAST) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign expired = (cnt == LAST);
endmodule

// File: rtl/pll_seq_regs.sv
module pll_seq_regs #(
   parameter int CFG_W    = 35,
   parameter int ROLLBACK = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cap,
   input  logic [CFG_W-1:0] req_cfg,
   input  logic             swap,
   input  logic             load,
   output logic [CFG_W-1:0] cfg_o
);
   logic [CFG_W-1:0] target;
   logic [CFG_W-1:0] snap;

   generate
      if (ROLLBACK != 0) begin : g_snap
         logic [CFG_W-1:0] snap_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               snap_q <= '0;
            end else if (cap) begin
               snap_q <= cfg_o;
            end
         end
         assign snap = snap_q;
      end else begin : g_nosnap
         assign snap = target;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         target <= '0;
      end else if (cap) begin
         target <= req_cfg;
      end else if (swap) begin
         target <= snap;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_o <= '0;
      end else if (load) begin
         cfg_o <= target;
      end
   end
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
   import pll_seq_pkg::*;
#(
   parameter int ROLLBACK = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic req_valid,
   input  logic en_cmd,
   input  logic dis_cmd,
   input  logic mux_wr,
   input  logic mux_wr_normal,
   input  logic lock_in,
   input  logic tmo,
   output logic cap,
   output logic swap,
   output logic load,
   output logic tclr,
   output logic mux_normal,
   output logic pll_pd,
   output logic busy,
   output logic done,
   output logic fail,
   output logic err
);
   localparam bit CAN_RETRY = (ROLLBACK != 0);

   seq_state_e state;
   logic       moved;
   logic       second;

   wire wait_tmo = (state == ST_WAIT) && !lock_in && tmo;

   assign cap  = (state == ST_IDLE) && req_valid;
   assign swap = wait_tmo && !second && CAN_RETRY;
   assign load = (state == ST_LOAD);
   assign tclr = (state == ST_PUP) ||
                 ((state == ST_IDLE) && !req_valid && en_cmd);
   assign busy = (state != ST_IDLE);
   assign done = (state == ST_FIN);

   always_ff @(posedge clk) begin
      if (rst) begin
         state      <= ST_IDLE;
         mux_normal <= 1'b0;
         pll_pd     <= 1'b0;
         moved      <= 1'b0;
         second     <= 1'b0;
         fail       <= 1'b0;
         err        <= 1'b0;
      end else begin
         err <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  moved  <= mux_normal;
                  second <= 1'b0;
                  fail   <= 1'b0;
                  state  <= ST_PARK;
               end else if (en_cmd) begin
                  pll_pd <= 1'b0;
                  moved  <= 1'b0;
                  second <= 1'b1;
                  fail   <= 1'b0;
                  state  <= ST_WAIT;
               end else if (dis_cmd) begin
                  pll_pd <= 1'b1;
                  fail   <= 1'b0;
                  state  <= ST_FIN;
               end else if (mux_wr) begin
                  mux_normal <= mux_wr_normal;
               end
            end
            ST_PARK: begin
               mux_normal <= 1'b0;
               state      <= ST_PDOWN;
            end
            ST_PDOWN: begin
               pll_pd <= 1'b1;
               state  <= ST_LOAD;
            end
            ST_LOAD: begin
               state <= ST_PUP;
            end
            ST_PUP: begin
               pll_pd <= 1'b0;
               state  <= ST_WAIT;
            end
            ST_WAIT: begin
               if (lock_in) begin
                  state <= ST_UNPARK;
               end else if (tmo) begin
                  if (!second) begin
                     err <= 1'b1;
                  end
                  if (!second && CAN_RETRY) begin
                     second <= 1'b1;
                     state  <= ST_PDOWN;
                  end else begin
                     fail  <= 1'b1;
                     state <= ST_UNPARK;
                  end
               end
            end
            ST_UNPARK: begin
               if (moved) begin
                  mux_normal <= 1'b1;
               end
               state <= ST_FIN;
            end
            default: begin
               state <= ST_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq #(
   parameter int M_W          = 10,
   parameter int P_W          = 6,
   parameter int S_W          = 3,
   parameter int K_W          = 16,
   parameter int LOCK_TIMEOUT = 24000,
   parameter int ROLLBACK     = 1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           req_valid,
   input  logic [M_W-1:0] req_m,
   input  logic [P_W-1:0] req_p,
   input  logic [S_W-1:0] req_s,
   input  logic [K_W-1:0] req_k,
   input  logic           en_cmd,
   input  logic           dis_cmd,
   input  logic           mux_wr,
   input  logic           mux_wr_normal,
   input  logic           lock_in,
   output logic           mux_normal,
   output logic           pll_pd,
   output logic [M_W-1:0] cfg_m,
   output logic [P_W-1:0] cfg_p,
   output logic [S_W-1:0] cfg_s,
   output logic [K_W-1:0] cfg_k,
   output logic           enabled,
   output logic           busy,
   output logic           done,
   output logic           fail,
   output logic           err
);
   localparam int CFG_W = M_W + P_W + S_W + K_W;

   generate
      if (M_W < 1 || P_W < 1 || S_W < 1 || K_W < 1) begin : g_bad_width
         $error("pll_reprog_seq: every setting field needs at least one bit");
      end
      if (LOCK_TIMEOUT < 2) begin : g_bad_timeout
         $error("pll_reprog_seq: LOCK_TIMEOUT must be at least 2");
      end
   endgenerate

   logic             cap, swap, load, tclr, tmo;
   logic [CFG_W-1:0] cfg;

   pll_seq_ctrl #(
      .ROLLBACK(ROLLBACK)
   ) u_ctrl (
      .clk          (clk),
      .rst          (rst),
      .req_valid    (req_valid),
      .en_cmd       (en_cmd),
      .dis_cmd      (dis_cmd),
      .mux_wr       (mux_wr),
      .mux_wr_normal(mux_wr_normal),
      .lock_in      (lock_in),
      .tmo          (tmo),
      .cap          (cap),
      .swap         (swap),
      .load         (load),
      .tclr         (tclr),
      .mux_normal   (mux_normal),
      .pll_pd       (pll_pd),
      .busy         (busy),
      .done         (done),
      .fail         (fail),
      .err          (err)
   );

   pll_seq_regs #(
      .CFG_W   (CFG_W),
      .ROLLBACK(ROLLBACK)
   ) u_regs (
      .clk    (clk),
      .rst    (rst),
      .cap    (cap),
      .req_cfg({req_m, req_p, req_s, req_k}),
      .swap   (swap),
      .load   (load),
      .cfg_o  (cfg)
   );

   pll_lock_timer #(
      .LIMIT(LOCK_TIMEOUT)
   ) u_timer (
      .clk    (clk),
      .rst    (rst),
      .clr    (tclr),
      .expired(tmo)
   );

   assign {cfg_m, cfg_p, cfg_s, cfg_k} = cfg;
   assign enabled = !pll_pd;
endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk #(
   parameter int CFG_W = 35
) (
   input logic             clk,
   input logic             rst,
   input logic             busy,
   input logic             done,
   input logic             err,
   input logic             pll_pd,
   input logic             mux_normal,
   input logic [CFG_W-1:0] cfg
);
   // R3: settings may only move while powerdown is held across the edge
   a_r3_cfg_under_pd: assert property (@(posedge clk) disable iff (rst)
      (cfg != $past(cfg)) |-> (pll_pd && $past(pll_pd)));

   // R3: powerdown raised inside a sequence only with the slow clock selected
   a_r3_pd_after_park: assert property (@(posedge clk) disable iff (rst)
      ($rose(pll_pd) && $past(busy)) |-> !mux_normal);

   // R11: completion pulse falls inside the busy window
   a_r11_done_in_busy: assert property (@(posedge clk) disable iff (rst)
      done |-> busy);

   // R11: busy ends right after done
   a_r11_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
      done |=> !busy);

   // R6: error pulse lasts one cycle
   a_r6_err_single: assert property (@(posedge clk) disable iff (rst)
      err |=> !err);

   // R6: error pulse only while a sequence runs
   a_r6_err_in_busy: assert property (@(posedge clk) disable iff (rst)
      err |-> busy);
endmodule

bind pll_reprog_seq pll_reprog_seq_chk #(
   .CFG_W(M_W + P_W + S_W + K_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .busy      (busy),
   .done      (done),
   .err       (err),
   .pll_pd    (pll_pd),
   .mux_normal(mux_normal),
   .cfg       ({cfg_m, cfg_p, cfg_s, cfg_k})
);

// File: tb/pll_reprog_seq_test.sv
module pll_reprog_seq_test;
   localparam int TMO = 24000;
   localparam logic [9:0] BAD_M = 10'h3FF;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       req_valid = 1'b0;
   logic [9:0] req_m = '0;
   logic [5:0] req_p = '0;
   logic [2:0] req_s = '0;
   logic [15:0] req_k = '0;
   logic       en_cmd = 1'b0, dis_cmd = 1'b0, mux_wr = 1'b0, mux_wr_normal = 1'b0;
   logic       lock_in;
   logic       mux_normal, pll_pd, enabled, busy, done, fail, err;
   logic [9:0] cfg_m;
   logic [5:0] cfg_p;
   logic [2:0] cfg_s;
   logic [15:0] cfg_k;

   int total = 0;
   int passed = 0;
   int err_seen = 0;
   int lock_dly = 250;
   bit kill_lock = 1'b0;
   int lk_cnt = 0;

   always #2 clk = ~clk;

   pll_reprog_seq #(.LOCK_TIMEOUT(TMO)) uut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_m(req_m), .req_p(req_p),
      .req_s(req_s), .req_k(req_k), .en_cmd(en_cmd), .dis_cmd(dis_cmd),
      .mux_wr(mux_wr), .mux_wr_normal(mux_wr_normal), .lock_in(lock_in),
      .mux_normal(mux_normal), .pll_pd(pll_pd), .cfg_m(cfg_m), .cfg_p(cfg_p),
      .cfg_s(cfg_s), .cfg_k(cfg_k), .enabled(enabled), .busy(busy), .done(done),
      .fail(fail), .err(err)
   );

   // lock model: flag rises lock_dly cycles after powerdown falls
   always @(posedge clk) begin
      if (rst || pll_pd) lk_cnt <= 0;
      else if (lk_cnt < 1000000) lk_cnt <= lk_cnt + 1;
   end
   assign lock_in = !kill_lock && !pll_pd && (lk_cnt >= lock_dly) && (cfg_m != BAD_M);

   always @(negedge clk) if (err) err_seen <= err_seen + 1;

   task automatic chk(input string tag, input longint act, input longint exp);
      total++;
      if (act == exp) passed++;
      else $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
   endtask

   // after a one-cycle strobe, count cycles to done; also note any busy gap
   task automatic wait_done(output int n, output int gaps);
      n = 1;
      gaps = 0;
      while (!done && n < 60000) begin
         if (!busy) gaps++;
         @(negedge clk);
         n++;
      end
   endtask

   task automatic send_req(input logic [9:0] m, input logic [5:0] p,
                           input logic [2:0] s, input logic [15:0] k);
      @(negedge clk);
      req_m = m; req_p = p; req_s = s; req_k = k;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic set_mux(input logic v);
      @(negedge clk);
      mux_wr = 1'b1; mux_wr_normal = v;
      @(negedge clk);
      mux_wr = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 busy", busy, 0);
      chk("R1 done", done, 0);
      chk("R1 pd", pll_pd, 0);
      chk("R1 mux", mux_normal, 0);
      chk("R1 cfg", {cfg_m, cfg_p, cfg_s, cfg_k}, 0);
      chk("R10 enabled after reset", enabled, 1);
   endtask

   task automatic t_mux_write;
      set_mux(1'b1);
      chk("R2 mux set normal", mux_normal, 1);
      chk("R2 no busy", busy, 0);
      set_mux(1'b0);
      chk("R2 mux set slow", mux_normal, 0);
   endtask

   task automatic t_req_normal;
      int n, g;
      set_mux(1'b1);
      lock_dly = 250;
      err_seen = 0;
      send_req(10'd100, 6'd3, 3'd1, 16'h1234);
      chk("R11 busy after accept", busy, 1);
      chk("R3 mux unchanged in park cycle", mux_normal, 1);
      @(negedge clk);
      chk("R3 mux parked", mux_normal, 0);
      chk("R3 pd not yet", pll_pd, 0);
      @(negedge clk);
      chk("R3 pd raised", pll_pd, 1);
      chk("R3 cfg still old", cfg_m, 0);
      wait_done(n, g);
      n += 2;
      chk("R4 latency", n, 250 + 7);
      chk("R4 cfg", {cfg_m, cfg_p, cfg_s, cfg_k}, {10'd100, 6'd3, 3'd1, 16'h1234});
      chk("R4 fail", fail, 0);
      chk("R11 busy in done cycle", busy, 1);
      chk("R11 no busy gap", g, 0);
      chk("R6 no err", err_seen, 0);
      chk("R8 mux back to normal", mux_normal, 1);
      chk("R10 enabled", enabled, 1);
      @(negedge clk);
      chk("R11 idle after done", busy, 0);
   endtask

   task automatic t_req_slow;
      int n, g;
      set_mux(1'b0);
      lock_dly = 40;
      send_req(10'd200, 6'd2, 3'd2, 16'h0);
      wait_done(n, g);
      chk("R4 latency short lock", n, 40 + 7);
      chk("R4 cfg m", cfg_m, 200);
      chk("R8 mux stays slow", mux_normal, 0);
   endtask

   task automatic t_busy_ignore;
      int n, g;
      lock_dly = 100;
      send_req(10'd300, 6'd4, 3'd3, 16'h00AA);
      repeat (20) @(negedge clk);
      req_m = 10'd55; req_p = 6'd1; req_s = 3'd0; req_k = 16'h5555;
      req_valid = 1'b1; dis_cmd = 1'b1; mux_wr = 1'b1; mux_wr_normal = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; dis_cmd = 1'b0; mux_wr = 1'b0;
      wait_done(n, g);
      n += 21;
      chk("R11 latency unaffected", n, 100 + 7);
      chk("R11 cfg from first request", {cfg_m, cfg_p, cfg_s, cfg_k},
          {10'd300, 6'd4, 3'd3, 16'h00AA});
      chk("R11 dis ignored", pll_pd, 0);
      chk("R11 mux write ignored", mux_normal, 0);
      @(negedge clk);
      chk("R11 second request dropped", busy, 0);
   endtask

   task automatic t_timeout_restore;
      int n, g;
      set_mux(1'b1);
      lock_dly = 250;
      err_seen = 0;
      send_req(BAD_M, 6'd9, 3'd4, 16'hBEEF);
      wait_done(n, g);
      chk("R6 restore latency", n, TMO + 250 + 10);
      chk("R6 err once", err_seen, 1);
      chk("R6 fail clear", fail, 0);
      chk("R6 old cfg restored", {cfg_m, cfg_p, cfg_s, cfg_k},
          {10'd300, 6'd4, 3'd3, 16'h00AA});
      chk("R8 mux back after restore", mux_normal, 1);
   endtask

   task automatic t_lock_last_cycle;
      int n, g;
      lock_dly = TMO - 1;
      err_seen = 0;
      send_req(10'd77, 6'd5, 3'd5, 16'h0F0F);
      wait_done(n, g);
      chk("R5 lock in last cycle latency", n, TMO + 6);
      chk("R5 no err", err_seen, 0);
      chk("R5 new cfg kept", cfg_m, 77);
      chk("R5 fail clear", fail, 0);
   endtask

   task automatic t_double_fail;
      int n, g;
      lock_dly = TMO;
      err_seen = 0;
      send_req(10'd88, 6'd6, 3'd6, 16'h7777);
      wait_done(n, g);
      chk("R7 double timeout latency", n, 2 * TMO + 9);
      chk("R7 fail set", fail, 1);
      chk("R7 err once", err_seen, 1);
      chk("R7 restored cfg", {cfg_m, cfg_p, cfg_s, cfg_k},
          {10'd77, 6'd5, 3'd5, 16'h0F0F});
      chk("R8 mux back after failure", mux_normal, 1);
   endtask

   task automatic t_dis_en;
      int n, g;
      lock_dly = 250;
      @(negedge clk);
      dis_cmd = 1'b1;
      @(negedge clk);
      dis_cmd = 1'b0;
      chk("R9 disable done next cycle", done, 1);
      chk("R9 pd set", pll_pd, 1);
      chk("R10 enabled low", enabled, 0);
      chk("R9 cfg untouched by disable", cfg_m, 77);
      @(negedge clk);
      en_cmd = 1'b1;
      @(negedge clk);
      en_cmd = 1'b0;
      chk("R9 pd released", pll_pd, 0);
      wait_done(n, g);
      chk("R9 enable latency", n, 250 + 3);
      chk("R10 enabled high", enabled, 1);
      chk("R9 mux untouched", mux_normal, 1);
      chk("R9 cfg untouched by enable", cfg_m, 77);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_mux_write();
      t_req_normal();
      t_req_slow();
      t_busy_ignore();
      t_timeout_restore();
      t_lock_last_cycle();
      t_double_fail();
      t_dis_en();
      $display("%0d/%0d checks passed", passed, total);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", passed, total);
      $finish;
   end
endmodule